// File: doc/BRIEF.md
# Event Counter Bank with Overflow Interrupt

This block is a performance-monitor counter bank. It holds a build-time number of general event counters, at most 31, and one dedicated cycle counter. The counters are all 32 bits wide, or all 64 bits wide, as set by one parameter. Each general counter holds an event selector. Each cycle the selector picks one lane of a multi-lane event-delta bus, or the software-increment event. Whenever the counter is enabled, the picked delta is added to it.

Software configures and observes the bank through a single-cycle register port. One write can be made per cycle, and reads are combinational. The port gives access to:
- a control word: run, clear general counters, clear cycle counter, cycle prescale by 64;
- set/clear addresses for the count-enable, interrupt-enable and overflow-status masks;
- a software-increment address;
- per-counter selectors and values.

A counter that carries past its maximum wraps and sets its sticky overflow bit. If its interrupt-enable bit is set, the level interrupt output rises.

The event-delta bus has no back-pressure. The block accepts a delta on every cycle in which `ev_valid` is high, so there is no ready signal. A source that cannot present a delta simply drops `ev_valid`.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset, all counters, selectors, masks, the control word and the overflow status read zero, and `irq` is low.
- R2: General counter i adds the delta of its selected event at a clock edge only when the control run bit (control bit 0), its count-enable bit and, for hardware events, `ev_valid` are all high. Otherwise it holds.
- R3: Counters are 32 bits wide (the high-half address reads 0) unless the wide option is set. When an addition carries past the maximum, the value wraps modulo 2^width, which leaves the excess beyond the maximum minus one, and the counter's overflow-status bit is set in the same edge.
- R4: An overflow raises `irq` at the same edge only if that counter's interrupt-enable bit is set. An overflow with the bit clear leaves `irq` unchanged.
- R5: `irq` stays high until a write to an overflow-status set or clear address takes the status from nonzero to all-zero. It then drops at that edge.
- R6: The count-enable (set 0x01 / clear 0x02), interrupt-enable (0x03 / 0x04) and overflow (0x05 / 0x06) masks change only in the bit positions written as one. Either address reads the mask. Bits 0..N-1 belong to the general counters and bit 31 to the cycle counter.
- R7: A write to 0x07 adds one to each enabled general counter whose bit is one in the written value and whose selector is 0. No other counter changes.
- R8: Writing control bit 1 zeroes every general counter and leaves the cycle counter unchanged. Writing control bit 2 zeroes only the cycle counter and its prescale remainder.
- R9: When it is enabled (run bit and enable bit 31), the cycle counter advances by one per clock. With control bit 3 set, it advances once per 64 enabled clocks.
- R10: If a register write and an increment hit the same counter in one cycle, the written value is stored and the increment is lost.
- R11: Selector value 0 picks the software increment, and value k in 1..NUM_SRC picks event lane k-1 (lane k-1 is `ev_delta` bits [k*DELTA_W-1:(k-1)*DELTA_W]). Any other value counts nothing.
- R12: Register map (7-bit word addresses):
  - control: 0x00;
  - selector of counter i: 0x20+i;
  - low half of counter i: 0x40+2i, high half: 0x41+2i;
  - cycle counter: 0x7E (low) and 0x7F (high).
  Writes take effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 7 | Register read address |
| rd_data | output | 32 | Combinational read data |
| ev_valid | input | 1 | Qualifies the event-delta lanes this cycle |
| ev_delta | input | NUM_SRC*DELTA_W | Packed per-event count deltas |
| irq | output | 1 | Level overflow interrupt |

## Verification
Some properties are checked on every cycle:
- `irq` is never high while the overflow status is all-zero;
- overflow bits never drop without a register write;
- no counter moves while the run bit is low and no write occurs;
- a general-counter clear leaves all general counters zero;
- a write to counter 0 always stores the written value.

The exact wrap value, the interrupt-enable gating, the software-increment selection, the selector lane mapping and the divide-by-64 timing depend on the stimulus. Only the bench's directed scenarios show these.

// File: rtl/pcb_pkg.sv
`timescale 1ns/1ps
package pcb_pkg;
  localparam int ADDR_W = 7;
  localparam logic [ADDR_W-1:0] A_CTRL      = 7'h00;
  localparam logic [ADDR_W-1:0] A_CEN_SET   = 7'h01;
  localparam logic [ADDR_W-1:0] A_CEN_CLR   = 7'h02;
  localparam logic [ADDR_W-1:0] A_IEN_SET   = 7'h03;
  localparam logic [ADDR_W-1:0] A_IEN_CLR   = 7'h04;
  localparam logic [ADDR_W-1:0] A_OVF_SET   = 7'h05;
  localparam logic [ADDR_W-1:0] A_OVF_CLR   = 7'h06;
  localparam logic [ADDR_W-1:0] A_SWINC     = 7'h07;
  localparam logic [ADDR_W-1:0] A_SEL_BASE  = 7'h20;
  localparam logic [ADDR_W-1:0] A_CNT_BASE  = 7'h40;
  localparam logic [ADDR_W-1:0] A_CYC_LO    = 7'h7E;
  localparam logic [ADDR_W-1:0] A_CYC_HI    = 7'h7F;
  localparam int CYC_BIT  = 31;
  localparam int MAX_EVT  = 31;
  localparam int SEL_W    = 8;

  // control word bit positions
  localparam int C_RUN    = 0;
  localparam int C_GCLR   = 1;
  localparam int C_CCLR   = 2;
  localparam int C_DIV    = 3;
endpackage

// File: rtl/pcb_counter.sv
`timescale 1ns/1ps
module pcb_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_en,
  input  logic [W-1:0] delta,
  input  logic         zero,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [31:0]  wr_data,
  output logic [W-1:0] value,
  output logic         wrapped
);
  localparam bit HAS_HI = (W > 32);

  logic [W:0]   sum;
  logic [W-1:0] wr_val;
  logic         any_wr;

  assign sum    = {1'b0, value} + {1'b0, delta};
  assign any_wr = wr_lo | (wr_hi & HAS_HI);

  if (HAS_HI) begin : g_wide
    always_comb begin
      wr_val = value;
      if (wr_lo) wr_val[31:0]  = wr_data;
      if (wr_hi) wr_val[W-1:32] = wr_data[W-33:0];
    end
  end else begin : g_narrow
    logic hi_unused;
    assign hi_unused = wr_hi;
    always_comb wr_val = wr_data[W-1:0];
  end

  // a write beats a clear, which beats an increment
  assign wrapped = inc_en & sum[W] & ~any_wr & ~zero;

  always_ff @(posedge clk) begin
    if (!rst_n)       value <= '0;
    else if (any_wr)  value <= wr_val;
    else if (zero)    value <= '0;
    else if (inc_en)  value <= sum[W-1:0];
  end
endmodule

// File: rtl/pcb_cycdiv.sv
`timescale 1ns/1ps
module pcb_cycdiv #(
  parameter int DIV_LOG2 = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic div_on,
  input  logic clr,
  output logic step
);
  logic [DIV_LOG2-1:0] rem;

  assign step = run & (~div_on | (&rem));

  always_ff @(posedge clk) begin
    if (!rst_n)              rem <= '0;
    else if (clr)            rem <= '0;
    else if (run && div_on)  rem <= rem + 1'b1;
  end
endmodule

// File: rtl/pcb_irq.sv
`timescale 1ns/1ps
module pcb_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic status_wr,
  input  logic status_any,
  input  logic status_any_nxt,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)                                        irq <= 1'b0;
    else if (raise)                                    irq <= 1'b1;
    else if (status_wr && status_any && !status_any_nxt) irq <= 1'b0;
  end
endmodule

// File: rtl/perf_counter_bank.sv
`timescale 1ns/1ps
module perf_counter_bank
  import pcb_pkg::*;
#(
  parameter int NUM_EVT = 4,
  parameter bit WIDE    = 1'b0,
  parameter int NUM_SRC = 4,
  parameter int DELTA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [6:0]                 wr_addr,
  input  logic [31:0]                wr_data,
  input  logic [6:0]                 rd_addr,
  output logic [31:0]                rd_data,
  input  logic                       ev_valid,
  input  logic [NUM_SRC*DELTA_W-1:0] ev_delta,
  output logic                       irq
);
  localparam int CW = WIDE ? 64 : 32;
  localparam int NC = NUM_EVT + 1;
  localparam logic [31:0] VALID = ((32'd1 << NUM_EVT) - 32'd1) | (32'd1 << CYC_BIT);

  if (NUM_EVT < 1 || NUM_EVT > MAX_EVT) begin : g_cfg_bad
    $error("perf_counter_bank: NUM_EVT must be 1..31");
  end

  // ---------------- write decode ----------------
  logic wr_ctrl, gen_clr, cyc_clr, sw_wr;
  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign gen_clr = wr_ctrl && wr_data[C_GCLR];
  assign cyc_clr = wr_ctrl && wr_data[C_CCLR];
  assign sw_wr   = wr_en && (wr_addr == A_SWINC);

  // ---------------- control and masks ----------------
  logic ctrl_run, ctrl_div;
  logic [31:0] cen, ien, ovf, ovf_nxt, hw_wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_run <= 1'b0;
      ctrl_div <= 1'b0;
    end else if (wr_ctrl) begin
      ctrl_run <= wr_data[C_RUN];
      ctrl_div <= wr_data[C_DIV];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cen <= '0;
      ien <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_CEN_SET) cen <= (cen | wr_data) & VALID;
      if (wr_addr == A_CEN_CLR) cen <= cen & ~wr_data;
      if (wr_addr == A_IEN_SET) ien <= (ien | wr_data) & VALID;
      if (wr_addr == A_IEN_CLR) ien <= ien & ~wr_data;
    end
  end

  logic ovf_wr;
  assign ovf_wr = wr_en && ((wr_addr == A_OVF_SET) || (wr_addr == A_OVF_CLR));

  always_comb begin
    ovf_nxt = ovf;
    if (wr_en && wr_addr == A_OVF_SET) ovf_nxt = ovf_nxt | wr_data;
    if (wr_en && wr_addr == A_OVF_CLR) ovf_nxt = ovf_nxt & ~wr_data;
    ovf_nxt = (ovf_nxt | hw_wrap) & VALID;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ovf <= '0;
    else        ovf <= ovf_nxt;
  end

  // ---------------- event selectors ----------------
  logic [SEL_W-1:0] evsel [NUM_EVT];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_EVT; i++) begin
      if (!rst_n) evsel[i] <= '0;
      else if (wr_en && wr_addr == A_SEL_BASE + 7'(i)) evsel[i] <= wr_data[SEL_W-1:0];
    end
  end

  // ---------------- general counters ----------------
  logic [CW-1:0]      cval [NUM_EVT];
  logic [63:0]        cv64 [NUM_EVT];
  logic [NUM_EVT-1:0] gwrap;
  logic [NC*CW-1:0]   cnt_flat;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_cnt
    logic [DELTA_W-1:0] d;
    logic wlo, whi;

    assign wlo = wr_en && (wr_addr == A_CNT_BASE + 7'(2*i));
    assign whi = wr_en && (wr_addr == A_CNT_BASE + 7'(2*i + 1));

    always_comb begin
      d = '0;
      if (evsel[i] == '0) begin
        d = DELTA_W'(sw_wr && wr_data[i]);
      end else begin
        for (int s = 0; s < NUM_SRC; s++)
          if (ev_valid && evsel[i] == SEL_W'(s + 1)) d = ev_delta[s*DELTA_W +: DELTA_W];
      end
    end

    pcb_counter #(.W(CW)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_en  (ctrl_run && cen[i]),
      .delta   (CW'(d)),
      .zero    (gen_clr),
      .wr_lo   (wlo),
      .wr_hi   (whi),
      .wr_data (wr_data),
      .value   (cval[i]),
      .wrapped (gwrap[i])
    );

    assign cv64[i] = 64'(cval[i]);
    assign cnt_flat[i*CW +: CW] = cval[i];
  end

  // ---------------- cycle counter ----------------
  logic          cyc_step, cyc_wrap;
  logic [CW-1:0] cyc_val;
  logic [63:0]   cyc64;

  pcb_cycdiv #(.DIV_LOG2(6)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (ctrl_run && cen[CYC_BIT]),
    .div_on (ctrl_div),
    .clr    (cyc_clr),
    .step   (cyc_step)
  );

  pcb_counter #(.W(CW)) u_cyc (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_en  (cyc_step),
    .delta   (CW'(1)),
    .zero    (cyc_clr),
    .wr_lo   (wr_en && wr_addr == A_CYC_LO),
    .wr_hi   (wr_en && wr_addr == A_CYC_HI),
    .wr_data (wr_data),
    .value   (cyc_val),
    .wrapped (cyc_wrap)
  );

  assign cyc64 = 64'(cyc_val);
  assign cnt_flat[NUM_EVT*CW +: CW] = cyc_val;

  always_comb begin
    hw_wrap = '0;
    hw_wrap[NUM_EVT-1:0] = gwrap;
    hw_wrap[CYC_BIT] = cyc_wrap;
  end

  // ---------------- interrupt ----------------
  pcb_irq u_irq (
    .clk            (clk),
    .rst_n          (rst_n),
    .raise          (|(hw_wrap & ien)),
    .status_wr      (ovf_wr),
    .status_any     (|ovf),
    .status_any_nxt (|ovf_nxt),
    .irq            (irq)
  );

  // ---------------- read mux ----------------
  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:                 rd_data = {28'd0, ctrl_div, 2'b00, ctrl_run};
      A_CEN_SET, A_CEN_CLR:   rd_data = cen;
      A_IEN_SET, A_IEN_CLR:   rd_data = ien;
      A_OVF_SET, A_OVF_CLR:   rd_data = ovf;
      A_CYC_LO:               rd_data = cyc64[31:0];
      A_CYC_HI:               rd_data = cyc64[63:32];
      default: begin
        for (int i = 0; i < NUM_EVT; i++) begin
          if (rd_addr == A_SEL_BASE + 7'(i))       rd_data = 32'(evsel[i]);
          if (rd_addr == A_CNT_BASE + 7'(2*i))     rd_data = cv64[i][31:0];
          if (rd_addr == A_CNT_BASE + 7'(2*i + 1)) rd_data = cv64[i][63:32];
        end
      end
    endcase
  end
endmodule

// File: rtl/pcb_checker.sv
`timescale 1ns/1ps
module pcb_checker
  import pcb_pkg::*;
#(
  parameter int NUM_EVT = 4,
  parameter int CW      = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic [6:0]                wr_addr,
  input logic [31:0]               wr_data,
  input logic                      ctrl_run,
  input logic                      irq,
  input logic [31:0]               ovf,
  input logic [(NUM_EVT+1)*CW-1:0] cnt_flat
);
  assert_irq_has_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf != 32'd0));

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((ovf & $past(ovf)) == $past(ovf)));

  assert_hold_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_run && !wr_en) |=> $stable(cnt_flat));

  assert_gen_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CTRL && wr_data[C_GCLR]) |=> (cnt_flat[NUM_EVT*CW-1:0] == '0));

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CNT_BASE) |=> (cnt_flat[31:0] == $past(wr_data)));
endmodule

bind perf_counter_bank pcb_checker #(.NUM_EVT(NUM_EVT), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .ctrl_run (ctrl_run),
  .irq      (irq),
  .ovf      (ovf),
  .cnt_flat (cnt_flat)
);

// File: tb/sim_perf_counter_bank.sv
`timescale 1ns/1ps
module sim_perf_counter_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [6:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        ev_valid = 1'b0;
  logic [31:0] ev_delta = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  perf_counter_bank #(.NUM_EVT(4), .WIDE(1'b0), .NUM_SRC(4), .DELTA_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ev_valid(ev_valid), .ev_delta(ev_delta), .irq(irq)
  );

  // {valid, delta, edges, expected counter 0}
  localparam logic [48:0] VEC [6] = '{
    {1'b1, 8'd3,   8'd2, 32'd6},
    {1'b1, 8'd0,   8'd5, 32'd6},
    {1'b1, 8'd1,   8'd4, 32'd10},
    {1'b1, 8'd255, 8'd1, 32'd265},
    {1'b1, 8'd17,  8'd3, 32'd316},
    {1'b0, 8'd9,   8'd3, 32'd316}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rdchk(input string req, input logic [6:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_edges(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [31:0] cyc_snap;

  initial begin
    run_edges(4);
    rst_n = 1'b1;
    run_edges(1);
    // R1 reset state
    rdchk("R1 ctrl", 7'h00, 0);
    rdchk("R1 cen", 7'h01, 0);
    rdchk("R1 ovf", 7'h05, 0);
    rdchk("R1 cnt0", 7'h40, 0);
    rdchk("R1 cyc", 7'h7E, 0);
    chk("R1 irq", 32'(irq), 0);

    // setup: c0<-lane0, c1,c2 software, c3<-lane1
    wr(7'h20, 1); wr(7'h23, 2);
    rdchk("R12 sel3", 7'h23, 2);
    wr(7'h01, 32'hF);
    rdchk("R6 cen set", 7'h01, 32'hF);
    wr(7'h00, 1);

    // R2 vector table on counter 0
    foreach (VEC[v]) begin
      ev_valid = VEC[v][48];
      ev_delta = {24'd0, VEC[v][47:40]};
      run_edges(int'(VEC[v][39:32]));
      ev_valid = 1'b0; ev_delta = '0;
      rdchk("R2 table", 7'h40, VEC[v][31:0]);
    end
    rdchk("R11 lane1 idle", 7'h46, 0);

    // R2 gating by count-enable and run bit
    wr(7'h02, 32'h1);
    rdchk("R6 cen clr", 7'h02, 32'hE);
    ev_valid = 1'b1; ev_delta = 32'd5; run_edges(3); ev_valid = 1'b0; ev_delta = '0;
    rdchk("R2 cen off", 7'h40, 316);
    wr(7'h01, 32'h1);
    wr(7'h00, 0);
    ev_valid = 1'b1; ev_delta = 32'd5; run_edges(2); ev_valid = 1'b0; ev_delta = '0;
    rdchk("R2 run off", 7'h40, 316);
    wr(7'h00, 1);

    // R11 out-of-range selector
    wr(7'h20, 9);
    ev_valid = 1'b1; ev_delta = 32'h01010101; run_edges(2); ev_valid = 1'b0; ev_delta = '0;
    rdchk("R11 bad sel", 7'h40, 316);
    rdchk("R11 lane1", 7'h46, 2);

    // R7 software increment
    wr(7'h07, 32'h6);
    rdchk("R7 c1", 7'h42, 1);
    rdchk("R7 c2", 7'h44, 1);
    wr(7'h07, 32'h9);
    rdchk("R7 c0 not sw", 7'h40, 316);
    rdchk("R7 c3 not sw", 7'h46, 2);
    wr(7'h02, 32'h4);
    wr(7'h07, 32'h4);
    rdchk("R7 disabled", 7'h44, 1);

    // R4 overflow with interrupt-enable clear
    wr(7'h42, 32'hFFFF_FFFF);
    wr(7'h07, 32'h2);
    rdchk("R3 wrap c1", 7'h42, 0);
    rdchk("R3 ovf c1", 7'h05, 32'h2);
    chk("R4 no irq", 32'(irq), 0);

    // R3/R4 overflow with interrupt-enable set
    wr(7'h03, 32'h8);
    rdchk("R6 ien", 7'h04, 32'h8);
    wr(7'h46, 32'hFFFF_FFFE);
    ev_valid = 1'b1; ev_delta = 32'h0000_0500; run_edges(1); ev_valid = 1'b0; ev_delta = '0;
    rdchk("R3 wrap value", 7'h46, 3);
    rdchk("R3 hi half", 7'h47, 0);
    rdchk("R3 ovf", 7'h05, 32'hA);
    chk("R4 irq", 32'(irq), 1);

    // R5 clear path
    wr(7'h06, 32'h2);
    rdchk("R6 ovf clr", 7'h05, 32'h8);
    chk("R5 irq held", 32'(irq), 1);
    wr(7'h06, 32'h8);
    chk("R5 irq drop", 32'(irq), 0);
    wr(7'h05, 32'h1);
    rdchk("R6 ovf set", 7'h06, 32'h1);
    chk("R5 set no irq", 32'(irq), 0);
    wr(7'h06, 32'h1);

    // R10 write wins over same-cycle increment
    wr(7'h20, 1);
    @(negedge clk);
    ev_valid = 1'b1; ev_delta = 32'd7;
    wr_en = 1'b1; wr_addr = 7'h40; wr_data = 32'd100;
    @(negedge clk);
    wr_en = 1'b0;
    rdchk("R10 write wins", 7'h40, 100);
    @(negedge clk);
    ev_valid = 1'b0; ev_delta = '0;
    rdchk("R10 then count", 7'h40, 107);

    // R8 clears
    wr(7'h01, 32'h8000_0000);
    run_edges(5);
    wr(7'h00, 0);
    rd_addr = 7'h7E; #1; cyc_snap = rd_data;
    chk("R9 cyc ran", 32'(cyc_snap != 0), 1);
    wr(7'h00, 32'h2);
    rdchk("R8 c0 zero", 7'h40, 0);
    rdchk("R8 c3 zero", 7'h46, 0);
    rdchk("R8 cyc kept", 7'h7E, cyc_snap);
    wr(7'h00, 32'h4);
    rdchk("R8 cyc zero", 7'h7E, 0);

    // R9 per-clock and divide-by-64
    wr(7'h00, 32'h1);
    run_edges(10);
    rdchk("R9 per clock", 7'h7E, 10);
    wr(7'h00, 32'hD);
    rdchk("R9 div start", 7'h7E, 0);
    run_edges(63);
    rdchk("R9 div 63", 7'h7E, 0);
    run_edges(1);
    rdchk("R9 div 64", 7'h7E, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule